// File: doc/BRIEF.md
# Indexed Codec Control Register Block

This block is the control-port register file of an audio codec. A host reaches it through a 64-byte window that is decoded on word boundaries. That gives sixteen direct 32-bit registers. One direct register acts as a pointer into a second bank of thirty-two 8-bit registers. A neighbouring direct register is the data window through which the selected 8-bit register is read and written.

Some registers follow their own access rules. One indirect slot can only be written and always reads as zero. Two indirect slots are read-only, and one of them holds a fixed version code. One indirect slot keeps a single writable bit and has identification bits forced on. One direct register is locked at zero. Another direct register carries a self-clearing software reset. The bus port is a plain single-cycle strobe interface with no handshake. Read data is registered and appears one cycle after the read strobe. The interrupt output exists for board wiring and is held inactive.

Top module: `codec_regif`

## Requirements
- R1: The word number is addr[5:2]. Direct words 0, 3 and 5 to 15 store all 32 bits of a write and return them on a read.
- R2: The indirect index is bits [4:0] of direct word 0, and its upper bits are not used for the selection. A write of 0x25 to word 0 selects indirect slot 5, and word 0 still reads back 0x25.
- R3: A read of word 1 returns the selected indirect register, zero-extended to 32 bits. When the index is 3, the read returns 0.
- R4: A write to word 1 stores wdata[7:0] into the selected indirect register. Writes to indirect slots 11 and 25 are ignored.
- R5: A write to word 1 while the index is 12 stores (wdata & 0x40) | 0x8A. Writing 0xFF gives 0xCA, and writing 0x00 gives 0x8A.
- R6: After a reset, every direct and indirect register is 0, except indirect slot 12, which is 0x8A, and indirect slot 25, which is 0xA0. After rst_n is released, rdata is 0.
- R7: Writes to word 2 are ignored, and word 2 always reads 0.
- R8: Word 4 stores wdata & 0x7F. When wdata[0] is 1, the same write also applies the full R6 reset to every other register, so word 4 then reads the masked value with bit 0 still set. When wdata[0] is 0, no other register changes.
- R9: rdata is updated only on a clock edge that samples rd_en high, and it holds its value otherwise. A read returns the register contents from before any write in the same cycle. irq is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, with the same effect as the software reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 6 | Byte address within the 64-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request, tied low |

## Verification
Assertions check on every cycle that slot 12 keeps its forced identification bits, that writes aimed at slot 11 leave it unchanged, and that a software reset clears the index word. They also check that word 4 takes the masked write value, that a window read at slot 3 yields zero, and that rdata stays stable whenever no read is strobed. The bench scenarios are needed to show the end-to-end paths. These are the 5-bit index wrap, the zero-extended read-back through the window, the full set of reset values restored by a software reset, and the separation between a control write with bit 0 low and one with bit 0 high.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int N_DIR     = 16;
  localparam int N_IND     = 32;
  localparam int IND_W     = 8;
  localparam int DIR_SEL_W = $clog2(N_DIR);
  localparam int IND_SEL_W = $clog2(N_IND);

  // direct word roles
  localparam int W_INDEX  = 0;
  localparam int W_WINDOW = 1;
  localparam int W_LOCKED = 2;
  localparam int W_CTRL   = 4;

  // indirect slot roles
  localparam int S_WRONLY  = 3;
  localparam int S_RO_A    = 11;
  localparam int S_MASKED  = 12;
  localparam int S_VERSION = 25;

  localparam logic [7:0]  CODEC_ID   = 8'h8A;
  localparam logic [7:0]  CHIP_VER   = 8'hA0;
  localparam logic [7:0]  MASKED_KEEP = 8'h40;
  localparam logic [31:0] CTRL_KEEP  = 32'h0000_007F;
endpackage

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regif_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int ND  = N_DIR,
  localparam int SW = $clog2(ND)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_sel,
  input  logic [DW-1:0]        wdata,
  input  logic                 soft_rst,
  output logic [ND-1:0][DW-1:0] dir_q
);
  for (genvar g = 0; g < ND; g++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en && (wr_sel == SW'(g));
    if (g == W_WINDOW || g == W_LOCKED) begin : g_none
      // window has no storage of its own; locked word never takes writes
      assign q = '0;
    end else if (g == W_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (hit)    q <= wdata & DW'(CTRL_KEEP);
        else if (soft_rst) q <= '0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (soft_rst) q <= '0;
        else if (hit)      q <= wdata;
      end
    end
    assign dir_q[g] = q;
  end

  assert_soft_rst_clears_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (dir_q[W_INDEX] == '0));

  assert_ctrl_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SW'(W_CTRL)) |=> (dir_q[W_CTRL] == ($past(wdata) & DW'(CTRL_KEEP))));
endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regif_pkg::*;
#(
  parameter int IW  = IND_W,
  parameter int NI  = N_IND,
  localparam int XW = $clog2(NI)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [XW-1:0]        idx,
  input  logic [IW-1:0]        wdata,
  input  logic                 soft_rst,
  output logic [NI-1:0][IW-1:0] ind_q
);
  function automatic logic [IW-1:0] init_val(input int slot);
    if (slot == S_MASKED)  return IW'(CODEC_ID);
    if (slot == S_VERSION) return IW'(CHIP_VER);
    return '0;
  endfunction

  for (genvar g = 0; g < NI; g++) begin : g_slot
    logic [IW-1:0] q;
    logic          hit;
    assign hit = wr_en && (idx == XW'(g));
    if (g == S_RO_A || g == S_VERSION) begin : g_ro
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= init_val(g);
        else if (soft_rst) q <= init_val(g);
      end
    end else if (g == S_MASKED) begin : g_masked
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= init_val(g);
        else if (soft_rst) q <= init_val(g);
        else if (hit)      q <= (wdata & IW'(MASKED_KEEP)) | IW'(CODEC_ID);
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= init_val(g);
        else if (soft_rst) q <= init_val(g);
        else if (hit)      q <= wdata;
      end
    end
    assign ind_q[g] = q;
  end

  assert_ro_slot_unchanged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == XW'(S_RO_A) && !soft_rst) |=> $stable(ind_q[S_RO_A]));

  assert_masked_id_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ind_q[S_MASKED] & ~IW'(MASKED_KEEP)) == IW'(CODEC_ID)));
endmodule

// File: rtl/codec_read_port.sv
module codec_read_port
  import codec_regif_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int ND  = N_DIR,
  parameter int IW  = IND_W,
  parameter int NI  = N_IND,
  localparam int SW = $clog2(ND),
  localparam int XW = $clog2(NI)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [SW-1:0]         rd_sel,
  input  logic [XW-1:0]         idx,
  input  logic [ND-1:0][DW-1:0] dir_q,
  input  logic [NI-1:0][IW-1:0] ind_q,
  output logic [DW-1:0]         rdata
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    if (rd_sel == SW'(W_WINDOW)) begin
      if (idx == XW'(S_WRONLY)) rd_mux = '0;
      else                      rd_mux = DW'(ind_q[idx]);
    end else begin
      rd_mux = dir_q[rd_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_wronly_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SW'(W_WINDOW) && idx == XW'(S_WRONLY)) |=> (rdata == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int ND = N_DIR,
  parameter int NI = N_IND,
  parameter int IW = IND_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int SW = $clog2(ND);
  localparam int XW = $clog2(NI);

  logic [SW-1:0]         word;
  logic [XW-1:0]         idx;
  logic                  soft_rst;
  logic                  win_wr;
  logic [ND-1:0][DW-1:0] dir_q;
  logic [NI-1:0][IW-1:0] ind_q;
  logic [1:0]            unused_byte_lane;

  assign word             = addr[AW-1:2];
  assign unused_byte_lane = addr[1:0];
  assign idx              = dir_q[W_INDEX][XW-1:0];
  assign soft_rst         = wr_en && (word == SW'(W_CTRL)) && wdata[0];
  assign win_wr           = wr_en && (word == SW'(W_WINDOW));
  assign irq              = 1'b0;

  codec_direct_bank #(.DW(DW), .ND(ND)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(word),
    .wdata(wdata), .soft_rst(soft_rst), .dir_q(dir_q)
  );

  codec_indirect_bank #(.IW(IW), .NI(NI)) u_ind (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr), .idx(idx),
    .wdata(wdata[IW-1:0]), .soft_rst(soft_rst), .ind_q(ind_q)
  );

  codec_read_port #(.DW(DW), .ND(ND), .IW(IW), .NI(NI)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(word), .idx(idx),
    .dir_q(dir_q), .ind_q(ind_q), .rdata(rdata)
  );

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n) irq == 1'b0);
endmodule

// File: tb/tb_codec_regif.sv
module tb_codec_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  codec_regif dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R6 rdata after reset", rdata, 32'h0);
    check("R9 irq low", {31'h0, irq}, 32'h0);
    rd(6'h00, v); check("R6 index word zero", v, 32'h0);
    rd(6'h10, v); check("R6 ctrl word zero", v, 32'h0);
    wr(6'h00, 32'd12); rd(6'h04, v); check("R6 slot 12 init", v, 32'h8A);
    wr(6'h00, 32'd25); rd(6'h04, v); check("R6 slot 25 init", v, 32'hA0);
    wr(6'h00, 32'd7);  rd(6'h04, v); check("R6 slot 7 zero", v, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(6'h1C, 32'hDEADBEEF); rd(6'h1C, v); check("R1 word 7 full store", v, 32'hDEADBEEF);
    wr(6'h3C, 32'h12345678); rd(6'h3C, v); check("R1 word 15 full store", v, 32'h12345678);
    wr(6'h0C, 32'hA5A5_0F0F); rd(6'h0C, v); check("R1 word 3 full store", v, 32'hA5A50F0F);
    wr(6'h08, 32'hFFFFFFFF); rd(6'h08, v); check("R7 word 2 ignores write", v, 32'h0);
  endtask

  task automatic t_index_wrap();
    logic [31:0] v;
    wr(6'h00, 32'h25); rd(6'h00, v); check("R2 index word readback", v, 32'h25);
    wr(6'h04, 32'h177);
    wr(6'h00, 32'h05); rd(6'h04, v); check("R2 wrap selects slot 5, R4 low byte", v, 32'h77);
  endtask

  task automatic t_write_only();
    logic [31:0] v;
    wr(6'h00, 32'd3); wr(6'h04, 32'h55); rd(6'h04, v);
    check("R3 slot 3 reads zero", v, 32'h0);
  endtask

  task automatic t_read_only();
    logic [31:0] v;
    wr(6'h00, 32'd11); wr(6'h04, 32'h33); rd(6'h04, v); check("R4 slot 11 ignores write", v, 32'h0);
    wr(6'h00, 32'd25); wr(6'h04, 32'h11); rd(6'h04, v); check("R4 slot 25 ignores write", v, 32'hA0);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(6'h00, 32'd12);
    wr(6'h04, 32'hFF); rd(6'h04, v); check("R5 slot 12 after 0xFF", v, 32'hCA);
    wr(6'h04, 32'h00); rd(6'h04, v); check("R5 slot 12 after 0x00", v, 32'h8A);
    wr(6'h04, 32'h40); rd(6'h04, v); check("R5 slot 12 after 0x40", v, 32'hCA);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(6'h00, 32'd9); wr(6'h04, 32'h5A);
    wr(6'h10, 32'hFE);
    rd(6'h10, v); check("R8 ctrl masked no reset", v, 32'h7E);
    rd(6'h00, v); check("R8 index kept without bit0", v, 32'd9);
    wr(6'h10, 32'hFFFFFFFF);
    rd(6'h10, v); check("R8 ctrl keeps 0x7F", v, 32'h7F);
    rd(6'h00, v); check("R8 index cleared by soft reset", v, 32'h0);
    rd(6'h1C, v); check("R8 word 7 cleared", v, 32'h0);
    wr(6'h00, 32'd9);  rd(6'h04, v); check("R8 slot 9 cleared", v, 32'h0);
    wr(6'h00, 32'd12); rd(6'h04, v); check("R8 R6 slot 12 restored", v, 32'h8A);
    wr(6'h00, 32'd25); rd(6'h04, v); check("R8 R6 slot 25 restored", v, 32'hA0);
  endtask

  task automatic t_rd_hold();
    logic [31:0] v;
    rd(6'h10, v); check("R9 read ctrl", v, 32'h7F);
    wr(6'h10, 32'h02);
    repeat (3) @(negedge clk);
    check("R9 rdata held without read", rdata, 32'h7F);
    @(negedge clk);
    addr = 6'h10; rd_en = 1'b1; wr_en = 1'b1; wdata = 32'h3C;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R9 read sees pre-write value", rdata, 32'h02);
    rd(6'h10, v); check("R9 following read sees write", v, 32'h3C);
    check("R9 irq still low", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_index_wrap();
    t_write_only();
    t_read_only();
    t_masked();
    t_ctrl();
    t_rd_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule